// File: doc/BRIEF.md
# Dual-Channel Multiplexed Output Formatter

This block is the digital back end of a two-channel sampling converter. Each sample period it captures one result per channel, both taken at the same instant. It then places the two results, one after the other, on a single shared data bus. Channel A occupies the high half of the sample clock and channel B the low half. A channel flag on the bus says which channel the current word belongs to. The word is written either in straight offset binary or in two's complement, and the choice is made by one select input.

The block runs on a clock at twice the sample rate. The input `smp_phase` is 1 in each fast cycle that starts at a sample-clock rising edge and 0 in each cycle that starts at a falling edge. A sample is captured on every fast edge where `smp_phase` is 1 and no idle mode is active. Channel A is then driven 10 fast edges later and channel B 11 fast edges later. This gives the 5 and 5.5 sample-cycle latencies.

An active-low output enable turns off the bus. The off state is shown by a drive flag instead of a tri-state. A power-down input freezes the bus. A sleep input stops conversions and clears the pipeline. After wake-up, valid data returns only once fresh samples have travelled the full latency.

The controller is a four-state machine:
- `ST_REFILL` is the reset state. It waits for fresh data to reach the channel A tap.
- `ST_RUN` is steady streaming.
- `ST_DOZE` is entered while sleep is high.
- `ST_PDOWN` is entered while power-down is high.

The state transitions are:
- From `ST_RUN` or `ST_REFILL`, power-down leads to `ST_PDOWN`. Otherwise sleep leads to `ST_DOZE`.
- `ST_REFILL` moves to `ST_RUN` on the first channel A load.
- `ST_DOZE` and `ST_PDOWN` both move to `ST_PDOWN` if power-down is high, to `ST_DOZE` if only sleep is high, and to `ST_REFILL` when both are low.

Top module: `dmf_out_mux`

## Requirements
- R1: A sample pair captured at fast edge k (`smp_phase`=1, `sleep`=0, `pwr_dn`=0) puts the channel A word on `bus_data` at edge k+10, with `chan_flag`=1 and `out_valid`=1.
- R2: The channel B word of the same pair appears at edge k+11 with `chan_flag`=0 and `out_valid`=1.
- R3: With `twos_sel`=0 the word equals the input code (offset binary). With `twos_sel`=1, bit 9 of the input code is inverted. So code 0x200 becomes 0x000, 0x000 becomes 0x200, and 0x3FF becomes 0x1FF. The `twos_sel` value applied is the one present at the load edge.
- R4: While `oe_n`=1, `bus_drv` is 0 and `bus_data` and `chan_flag` read 0. The internal pipeline and hold registers keep running, so the correct word shows as soon as `oe_n` returns to 0.
- R5: On an edge where `pwr_dn`=1, the held word and flag do not change. The pipeline is cleared and `out_valid` goes to 0.
- R6: On an edge where `sleep`=1, the held word and flag do not change, `out_valid` goes to 0, and every in-flight sample is discarded. After wake-up, the first valid word is channel A, 10 edges after the first fresh capture.
- R7: `out_valid` is 1 after an edge that loaded a word and 0 after an edge that did not.
- R8: While `rst_n`=0, `bus_data`, `chan_flag` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_phase | input | 1 | 1 in the sample-clock high half, 0 in the low half |
| chan_a_code | input | 10 | Channel A conversion result, offset binary |
| chan_b_code | input | 10 | Channel B conversion result, offset binary |
| twos_sel | input | 1 | 1 selects two's complement, 0 selects offset binary |
| oe_n | input | 1 | Active-low output enable |
| pwr_dn | input | 1 | Power-down: freeze the outputs and clear the pipeline |
| sleep | input | 1 | Sleep: stop conversions and clear the pipeline |
| bus_data | output | 10 | Shared output word (0 when not driven) |
| bus_drv | output | 1 | 1 when the bus is driven |
| chan_flag | output | 1 | 1 for channel A data, 0 for channel B data |
| out_valid | output | 1 | Word loaded by the last edge |

## Verification
Fixed end-of-scale and mid-scale codes are sent under both coding selections. These separate the MSB inversion from any other bit change, and they also separate the channel A slot from the channel B slot. Random codes with random bursts of sleep, power-down and output disable check that each channel's word arrives exactly 10 or 11 edges after capture. They also check that a sample is dropped whenever an idle edge falls inside its flight window, and that held words survive the idle periods. The expected words come from a bench model of the capture history.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    typedef enum logic [1:0] {
        ST_REFILL = 2'd0,
        ST_RUN    = 2'd1,
        ST_DOZE   = 2'd2,
        ST_PDOWN  = 2'd3
    } dmf_state_e;

endpackage

// File: rtl/dmf_lat_pipe.sv
module dmf_lat_pipe #(
    parameter int W     = 10,
    parameter int DEPTH = 11,
    parameter int TAP_A = 9,
    parameter int TAP_B = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         flush,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         tap_a_vld,
    output logic [W-1:0] tap_a_code,
    output logic         tap_b_vld,
    output logic [W-1:0] tap_b_code
);

    logic [DEPTH-1:0] vld;
    logic [W-1:0]     sa [DEPTH];
    logic [W-1:0]     sb [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n || flush) vld[i] <= 1'b0;
                else                 vld[i] <= push;
                sa[i] <= in_a;
                sb[i] <= in_b;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n || flush) vld[i] <= 1'b0;
                else                 vld[i] <= vld[i-1];
                sa[i] <= sa[i-1];
                sb[i] <= sb[i-1];
            end
        end
    end

    assign tap_a_vld  = vld[TAP_A];
    assign tap_a_code = sa[TAP_A];
    assign tap_b_vld  = vld[TAP_B];
    assign tap_b_code = sb[TAP_B];

endmodule

// File: rtl/dmf_code_fmt.sv
module dmf_code_fmt #(
    parameter int W = 10
) (
    input  logic [W-1:0] code_in,
    input  logic         twos,
    output logic [W-1:0] code_out
);

    always_comb begin
        code_out        = code_in;
        code_out[W-1]   = code_in[W-1] ^ twos;
    end

endmodule

// File: rtl/dmf_mux_ctrl.sv
module dmf_mux_ctrl
    import dmf_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_phase,
    input  logic         sleep,
    input  logic         pwr_dn,
    input  logic         tap_a_vld,
    input  logic [W-1:0] word_a,
    input  logic         tap_b_vld,
    input  logic [W-1:0] word_b,
    output logic [W-1:0] bus_q,
    output logic         flag_q,
    output logic         valid_q,
    output dmf_state_e   state_q
);

    dmf_state_e state_d;
    logic       awake;
    logic       load_a;
    logic       load_b;

    assign awake  = (state_q == ST_RUN || state_q == ST_REFILL) && !sleep && !pwr_dn;
    assign load_a = awake && smp_phase && tap_a_vld;
    assign load_b = awake && !smp_phase && tap_b_vld;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (pwr_dn)     state_d = ST_PDOWN;
                else if (sleep) state_d = ST_DOZE;
            end
            ST_REFILL: begin
                if (pwr_dn)      state_d = ST_PDOWN;
                else if (sleep)  state_d = ST_DOZE;
                else if (load_a) state_d = ST_RUN;
            end
            ST_DOZE, ST_PDOWN: begin
                if (pwr_dn)     state_d = ST_PDOWN;
                else if (sleep) state_d = ST_DOZE;
                else            state_d = ST_REFILL;
            end
            default: state_d = ST_REFILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_REFILL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q   <= '0;
            flag_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (load_a) begin
            bus_q   <= word_a;
            flag_q  <= 1'b1;
            valid_q <= 1'b1;
        end else if (load_b) begin
            bus_q   <= word_b;
            flag_q  <= 1'b0;
            valid_q <= 1'b1;
        end else begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dmf_out_mux.sv
module dmf_out_mux
    import dmf_pkg::*;
#(
    parameter int W         = 10,
    parameter int LAT_A_HLF = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_phase,
    input  logic [W-1:0] chan_a_code,
    input  logic [W-1:0] chan_b_code,
    input  logic         twos_sel,
    input  logic         oe_n,
    input  logic         pwr_dn,
    input  logic         sleep,
    output logic [W-1:0] bus_data,
    output logic         bus_drv,
    output logic         chan_flag,
    output logic         out_valid
);

    localparam int LAT_B_HLF = LAT_A_HLF + 1;
    localparam int DEPTH     = LAT_B_HLF;

    logic         flush;
    logic         push;
    logic         tap_a_vld;
    logic         tap_b_vld;
    logic [W-1:0] tap_a_code;
    logic [W-1:0] tap_b_code;
    logic [W-1:0] word_a;
    logic [W-1:0] word_b;
    logic [W-1:0] bus_q;
    logic         flag_q;
    dmf_state_e   state_q;

    assign flush = sleep | pwr_dn;
    assign push  = smp_phase & ~flush;

    dmf_lat_pipe #(
        .W(W), .DEPTH(DEPTH), .TAP_A(LAT_A_HLF - 1), .TAP_B(LAT_B_HLF - 1)
    ) u_pipe (
        .clk(clk), .rst_n(rst_n), .push(push), .flush(flush),
        .in_a(chan_a_code), .in_b(chan_b_code),
        .tap_a_vld(tap_a_vld), .tap_a_code(tap_a_code),
        .tap_b_vld(tap_b_vld), .tap_b_code(tap_b_code)
    );

    dmf_code_fmt #(.W(W)) u_fmt_a (.code_in(tap_a_code), .twos(twos_sel), .code_out(word_a));
    dmf_code_fmt #(.W(W)) u_fmt_b (.code_in(tap_b_code), .twos(twos_sel), .code_out(word_b));

    dmf_mux_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_phase(smp_phase),
        .sleep(sleep), .pwr_dn(pwr_dn),
        .tap_a_vld(tap_a_vld), .word_a(word_a),
        .tap_b_vld(tap_b_vld), .word_b(word_b),
        .bus_q(bus_q), .flag_q(flag_q), .valid_q(out_valid), .state_q(state_q)
    );

    assign bus_drv   = ~oe_n;
    assign bus_data  = bus_drv ? bus_q : '0;
    assign chan_flag = bus_drv & flag_q;

endmodule

// File: rtl/dmf_out_mux_chk.sv
module dmf_out_mux_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smp_phase,
    input logic         sleep,
    input logic         pwr_dn,
    input logic         out_valid,
    input logic [W-1:0] bus_q,
    input logic         flag_q
);

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !flag_q && bus_q == '0));

    assert_pdown_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> ($stable(bus_q) && $stable(flag_q)));

    assert_sleep_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !out_valid);

    assert_flag_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_q == $past(smp_phase)));

    assert_valid_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!$past(sleep) && !$past(pwr_dn)));

endmodule

bind dmf_out_mux dmf_out_mux_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_phase(smp_phase), .sleep(sleep),
    .pwr_dn(pwr_dn), .out_valid(out_valid), .bus_q(bus_q), .flag_q(flag_q)
);

// File: tb/dmf_out_mux_tb.sv
module dmf_out_mux_tb;

    localparam int W   = 10;
    localparam int LAT = 10;
    localparam int HN  = 4096;

    logic         clk = 1'b0;
    logic         rst_n, smp_phase, twos_sel, oe_n, pwr_dn, sleep;
    logic [W-1:0] chan_a_code, chan_b_code;
    logic [W-1:0] bus_data;
    logic         bus_drv, chan_flag, out_valid;

    always #10 clk = ~clk;

    dmf_out_mux u_dut (
        .clk(clk), .rst_n(rst_n), .smp_phase(smp_phase),
        .chan_a_code(chan_a_code), .chan_b_code(chan_b_code),
        .twos_sel(twos_sel), .oe_n(oe_n), .pwr_dn(pwr_dn), .sleep(sleep),
        .bus_data(bus_data), .bus_drv(bus_drv), .chan_flag(chan_flag),
        .out_valid(out_valid)
    );

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit           ph_h [HN];
    bit           sl_h [HN];
    bit           pd_h [HN];
    bit           tw_h [HN];
    bit           oe_h [HN];
    logic [W-1:0] a_h  [HN];
    logic [W-1:0] b_h  [HN];
    logic [W-1:0] eb = '0;
    bit           ef = 0;
    bit           ev = 0;
    bit           lit_en = 0;
    logic [W-1:0] lit_a, lit_b;

    function automatic logic [W-1:0] coded(input logic [W-1:0] c, input bit tw);
        return tw ? (c ^ 10'h200) : c;
    endfunction

    function automatic bit quiet(input int lo, input int hi);
        for (int e = lo; e <= hi; e++)
            if (sl_h[e] || pd_h[e]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h (edge %0d)", tag, what, act, exp, n);
        end
    endtask

    task automatic cycle(input bit sl, input bit pd, input bit oe, input bit tw,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        bit lda, ldb;
        string tag;
        smp_phase = (n % 2 == 0);
        sleep = sl; pwr_dn = pd; oe_n = oe; twos_sel = tw;
        chan_a_code = a; chan_b_code = b;
        ph_h[n] = smp_phase; sl_h[n] = sl; pd_h[n] = pd; tw_h[n] = tw; oe_h[n] = oe;
        a_h[n] = a; b_h[n] = b;
        @(posedge clk);
        @(negedge clk);
        lda = (n >= LAT) && ph_h[n] && quiet(n - LAT, n);
        ldb = (n >= LAT + 1) && !ph_h[n] && quiet(n - LAT - 1, n);
        if (lda) begin
            eb = coded(a_h[n-LAT], tw_h[n]); ef = 1; ev = 1; tag = "R1";
        end else if (ldb) begin
            eb = coded(b_h[n-LAT-1], tw_h[n]); ef = 0; ev = 1; tag = "R2";
        end else begin
            ev = 0;
            tag = pd_h[n] ? "R5" : (sl_h[n] ? "R6" : "R7");
        end
        if (oe_h[n]) tag = "R4";
        chk(tag, "bus_drv", int'(bus_drv), int'(!oe_h[n]));
        chk(tag, "bus_data", int'(bus_data), oe_h[n] ? 0 : int'(eb));
        chk(tag, "chan_flag", int'(chan_flag), oe_h[n] ? 0 : int'(ef));
        chk("R7", "out_valid", int'(out_valid), int'(ev));
        if (lit_en && ev && !oe_h[n])
            chk("R3", "literal word", int'(bus_data), ef ? int'(lit_a) : int'(lit_b));
        n++;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=%0d exp=done", n);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 0; smp_phase = 1; sleep = 0; pwr_dn = 0; oe_n = 0; twos_sel = 0;
        chan_a_code = 10'h155; chan_b_code = 10'h2AA;
        repeat (3) @(negedge clk);
        chk("R8", "reset bus", int'(bus_data), 0);
        chk("R8", "reset flag", int'(chan_flag), 0);
        chk("R8", "reset valid", int'(out_valid), 0);
        rst_n = 1;

        // R3 coding corners, checked against literal words
        lit_a = 10'h000; lit_b = 10'h200;
        for (int i = 0; i < 30; i++) begin lit_en = (i >= 12); cycle(0, 0, 0, 1, 10'h200, 10'h000); end
        lit_a = 10'h1FF; lit_b = 10'h200;
        for (int i = 0; i < 30; i++) begin lit_en = (i >= 12); cycle(0, 0, 0, 1, 10'h3FF, 10'h000); end
        lit_a = 10'h3FF; lit_b = 10'h000;
        for (int i = 0; i < 30; i++) begin lit_en = (i >= 12); cycle(0, 0, 0, 0, 10'h3FF, 10'h000); end
        lit_en = 0;

        // R6 short and long sleep, R5 power-down, both together, R4 disable
        for (int i = 0; i < 40; i++) cycle(i == 5, 0, 0, 0, W'(i * 7), W'(i * 13));
        for (int i = 0; i < 40; i++) cycle(i >= 3 && i < 9, 0, 0, 1, W'(i * 11), W'(i * 5));
        for (int i = 0; i < 40; i++) cycle(0, i >= 4 && i < 12, 0, 0, W'(i * 3), W'(i * 17));
        for (int i = 0; i < 40; i++) cycle(i >= 2 && i < 8, i >= 4 && i < 10, i >= 6 && i < 14, 1, W'(i * 19), W'(i * 23));
        for (int i = 0; i < 30; i++) cycle(0, 0, i[2], 0, W'(i * 29), W'(i * 31));

        // constrained random mix
        begin
            int  sl_left = 0, pd_left = 0;
            bit  tw = 0;
            for (int i = 0; i < 2500; i++) begin
                if (sl_left == 0 && $urandom_range(99) < 3) sl_left = $urandom_range(8, 1);
                if (pd_left == 0 && $urandom_range(99) < 2) pd_left = $urandom_range(12, 1);
                if ($urandom_range(99) < 5) tw = ~tw;
                cycle(sl_left > 0, pd_left > 0, $urandom_range(99) < 10, tw,
                      W'($urandom), W'($urandom));
                if (sl_left > 0) sl_left--;
                if (pd_left > 0) pd_left--;
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule